// File: doc/BRIEF.md
# Shared-Event Performance Counter with Two-Thread Privilege Qualification

This block counts occurrences of a performance event that belongs to a processor core as a whole rather than to either of its two hardware threads. Each thread carries a two-bit privilege selection: one bit enables counting in supervisor mode and the other enables counting in user mode. On every clock the block merges both selections into one qualifier and applies it to the current privilege level of both threads. A one-cycle event pulse that passes the qualifier is staged in a register and then adds one to a wide counter.

Counting is suspended only while both threads are halted. A single halted thread leaves counting active. Software can clear the counter or load it with a value. A sticky overflow flag records a wrap from all-ones to zero. The selections are sampled every cycle, so software can change them between events without losing the accumulated count.

Top module: `shared_evt_counter`

## Requirements
- R1: While reset is asserted, and after it is released, `count` is zero and `ovf` is zero. An event pulse presented during reset is never counted.
- R2: If both select pairs are 00, no event is counted, whatever the privilege levels.
- R3: If either select pair is 11, every event is counted, whatever the privilege level of either thread. Select bit [1] enables supervisor and bit [0] enables user.
- R4: If one pair is 01 (user only) and the other is 01 or 00, an event is counted when at least one thread has privilege 0 (user).
- R5: If one pair is 10 (supervisor only) and the other is 10 or 00, an event is counted when at least one thread has privilege 1 (supervisor).
- R6: If one pair is 01 and the other is 10, every event is counted, whatever the privilege levels.
- R7: While both halt inputs are 1, no event is counted. With only one thread halted, counting proceeds under R2 to R6.
- R8: Each qualified event cycle adds exactly one. An event sampled at clock edge k shows in `count` after edge k+1.
- R9: An increment from all-ones to zero sets `ovf`. `ovf` then stays set until a clear.
- R10: `sw_clr` sets `count` and `ovf` to zero at the next edge. It takes priority over load and over a staged event.
- R11: `sw_ld` writes `sw_ld_val` into `count` at the next edge. It takes priority over a staged event and leaves `ovf` unchanged.
- R12: A change to either select pair takes effect on the next event and does not alter the accumulated count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| t0_sel | input | 2 | Thread 0 selection: [1] supervisor enable, [0] user enable |
| t1_sel | input | 2 | Thread 1 selection: [1] supervisor enable, [0] user enable |
| t0_priv | input | 1 | Thread 0 privilege: 1 supervisor, 0 user |
| t1_priv | input | 1 | Thread 1 privilege: 1 supervisor, 0 user |
| t0_halt | input | 1 | Thread 0 halted |
| t1_halt | input | 1 | Thread 1 halted |
| evt_in | input | 1 | Event pulse for this cycle |
| sw_clr | input | 1 | Synchronous clear of count and overflow |
| sw_ld | input | 1 | Synchronous load of count |
| sw_ld_val | input | CNT_W | Value written by a load |
| count | output | CNT_W | Current count |
| ovf | output | 1 | Sticky overflow flag |

## Verification
Two situations are hard to reach from the ports. The first is an overflow, which needs the counter at all-ones, far out of reach by incrementing. The stimulus therefore loads all-ones and then sends one event. The second is a collision between a staged event and a load or clear. To create it, the stimulus raises the event in one cycle and the load or clear in the next, so both meet at the same counter edge. Beyond these, the qualifier table is walked without clearing between rows, so every row checks the new selection and the preserved running total together.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int NTHR       = 2;
  localparam int DEF_CNT_W  = 40;
  localparam int SEL_SUP    = 1;
  localparam int SEL_USR    = 0;

  typedef logic [NTHR-1:0][1:0] sel_vec_t;
endpackage

// File: rtl/evc_rst_sync.sv
module evc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shf_q;
  logic [STAGES-1:0] shf_d;

  always_comb begin
    shf_d = {shf_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shf_q <= '0;
    else        shf_q <= shf_d;
  end

  assign rst_sync_n = shf_q[STAGES-1];
endmodule

// File: rtl/evc_qual.sv
module evc_qual
  import evc_pkg::*;
(
  input  sel_vec_t            sel,
  input  logic [NTHR-1:0]     priv,
  input  logic [NTHR-1:0]     halt,
  output logic                qual,
  output logic                all_halt
);
  logic [NTHR-1:0] sup_bits;
  logic [NTHR-1:0] usr_bits;
  logic [NTHR-1:0] thr_hit;
  logic            sup_any;
  logic            usr_any;

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    assign sup_bits[g] = sel[g][SEL_SUP];
    assign usr_bits[g] = sel[g][SEL_USR];
  end

  assign sup_any = |sup_bits;
  assign usr_any = |usr_bits;

  for (genvar g = 0; g < NTHR; g++) begin : g_hit
    assign thr_hit[g] = priv[g] ? sup_any : usr_any;
  end

  assign qual     = (sup_any & usr_any) | (|thr_hit);
  assign all_halt = &halt;
endmodule

// File: rtl/evc_stage.sv
module evc_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_in,
  input  logic qual,
  input  logic all_halt,
  output logic evt_q
);
  logic evt_d;

  always_comb begin
    evt_d = evt_in & qual & ~all_halt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= evt_d;
  end

  AST_HALT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    all_halt |=> !evt_q) else $error("halted pair staged an event"); // R7
endmodule

// File: rtl/evc_core.sv
module evc_core #(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q
);
  logic [CNT_W-1:0] cnt_d;
  logic             ovf_d;
  logic             carry;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    ovf_d  = ovf_q;
    carry  = 1'b0;
    if (clr) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (ld) begin
      cnt_d = ld_val;
    end else if (inc) begin
      {carry, cnt_d} = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
      if (carry) ovf_d = 1'b1;
    end
  end

  assign cnt_en = clr | ld | inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0) && !ovf_q) else $error("clear failed"); // R10
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !clr) |=> (cnt_q == $past(ld_val))) else $error("load failed"); // R11
  AST_LOAD_KEEPS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !clr) |=> (ovf_q == $past(ovf_q))) else $error("load touched ovf"); // R11
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld && !clr) |=> (cnt_q == $past(cnt_q) + 1'b1)) else $error("bad step"); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !ld && !clr) |=> $stable(cnt_q)) else $error("count drifted"); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr) |=> ovf_q) else $error("ovf dropped"); // R9
  AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld && !clr && (&cnt_q)) |=> ovf_q) else $error("wrap lost"); // R9
endmodule

// File: rtl/shared_evt_counter.sv
module shared_evt_counter
  import evc_pkg::*;
#(
  parameter int CNT_W       = DEF_CNT_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       t0_sel,
  input  logic [1:0]       t1_sel,
  input  logic             t0_priv,
  input  logic             t1_priv,
  input  logic             t0_halt,
  input  logic             t1_halt,
  input  logic             evt_in,
  input  logic             sw_clr,
  input  logic             sw_ld,
  input  logic [CNT_W-1:0] sw_ld_val,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  logic            rst_sync_n;
  sel_vec_t        sel;
  logic [NTHR-1:0] priv;
  logic [NTHR-1:0] halt;
  logic            qual;
  logic            all_halt;
  logic            evt_q;

  assign sel[0] = t0_sel;
  assign sel[1] = t1_sel;
  assign priv   = {t1_priv, t0_priv};
  assign halt   = {t1_halt, t0_halt};

  evc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  evc_qual u_qual (
    .sel      (sel),
    .priv     (priv),
    .halt     (halt),
    .qual     (qual),
    .all_halt (all_halt)
  );

  evc_stage u_stage (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .evt_in   (evt_in),
    .qual     (qual),
    .all_halt (all_halt),
    .evt_q    (evt_q)
  );

  evc_core #(.CNT_W(CNT_W)) u_core (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .inc    (evt_q),
    .clr    (sw_clr),
    .ld     (sw_ld),
    .ld_val (sw_ld_val),
    .cnt_q  (count),
    .ovf_q  (ovf)
  );

  AST_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (t0_sel == 2'b00 && t1_sel == 2'b00) |=> !evt_q) else $error("unselected count"); // R2
  AST_FULL_SELECT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (evt_in && !(t0_halt && t1_halt) && (t0_sel == 2'b11 || t1_sel == 2'b11)) |=> evt_q)
    else $error("select-all missed"); // R3
  AST_MIXED_SELECT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (evt_in && !(t0_halt && t1_halt) &&
     ((t0_sel == 2'b01 && t1_sel == 2'b10) || (t0_sel == 2'b10 && t1_sel == 2'b01))) |=> evt_q)
    else $error("mixed select missed"); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_n |-> (count == '0) && !ovf) else $error("reset state wrong"); // R1
endmodule

// File: tb/tb_shared_evt_counter.sv
module tb_shared_evt_counter;
  localparam int CW       = 40;
  localparam int CLK_PER  = 10;
  localparam int WDOG_LIM = 5000;
  localparam int NVEC     = 17;

  // {t0_sel, t1_sel, t0_priv, t1_priv, t0_halt, t1_halt, expect}
  localparam logic [8:0] VEC [NVEC] = '{
    9'b00_00_0_0_0_0_0, // R2
    9'b00_00_1_1_0_0_0, // R2
    9'b11_00_0_1_0_0_1, // R3
    9'b00_11_1_1_0_0_1, // R3
    9'b01_00_1_1_0_0_0, // R4
    9'b01_00_1_0_0_0_1, // R4
    9'b00_01_0_1_0_0_1, // R4
    9'b01_01_1_1_0_0_0, // R4
    9'b10_00_0_0_0_0_0, // R5
    9'b00_10_0_1_0_0_1, // R5
    9'b10_10_1_0_0_0_1, // R5
    9'b01_10_0_0_0_0_1, // R6
    9'b10_01_1_1_0_0_1, // R6
    9'b11_11_0_0_1_1_0, // R7
    9'b11_00_0_0_1_0_1, // R7
    9'b01_00_1_0_0_1_1, // R7
    9'b10_10_1_1_1_1_0  // R7
  };

  logic clk = 1'b0;
  logic rst_n, t0_priv, t1_priv, t0_halt, t1_halt, evt_in, sw_clr, sw_ld, ovf;
  logic [1:0] t0_sel, t1_sel;
  logic [CW-1:0] sw_ld_val, count, exp_cnt;
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  shared_evt_counter #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .t0_sel(t0_sel), .t1_sel(t1_sel),
    .t0_priv(t0_priv), .t1_priv(t1_priv), .t0_halt(t0_halt), .t1_halt(t1_halt),
    .evt_in(evt_in), .sw_clr(sw_clr), .sw_ld(sw_ld), .sw_ld_val(sw_ld_val),
    .count(count), .ovf(ovf)
  );

  always #(CLK_PER/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG_LIM) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, WDOG_LIM);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [CW-1:0] act, input logic [CW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse();
    evt_in = 1'b1;
    step(1);
    evt_in = 1'b0;
    step(2);
  endtask

  initial begin
    rst_n = 1'b0; t0_sel = 2'b11; t1_sel = 2'b11; t0_priv = 1'b0; t1_priv = 1'b0;
    t0_halt = 1'b0; t1_halt = 1'b0; evt_in = 1'b1; sw_clr = 1'b0; sw_ld = 1'b0;
    sw_ld_val = '0;
    step(4);
    chk(count, '0, "R1 count in reset");
    chk({39'd0, ovf}, '0, "R1 ovf in reset");
    evt_in = 1'b0;
    rst_n  = 1'b1;
    step(5);
    chk(count, '0, "R1 count after release");
    chk({39'd0, ovf}, '0, "R1 ovf after release");

    exp_cnt = '0;
    for (int i = 0; i < NVEC; i++) begin
      {t0_sel, t1_sel, t0_priv, t1_priv, t0_halt, t1_halt} = VEC[i][8:1];
      pulse();
      exp_cnt = exp_cnt + {39'd0, VEC[i][0]};
      chk(count, exp_cnt, $sformatf("R12 running total, row %0d (R2 R3 R4 R5 R6 R7)", i));
    end
    t0_halt = 1'b0; t1_halt = 1'b0;

    // R8 latency and burst
    t0_sel = 2'b11; t1_sel = 2'b00;
    evt_in = 1'b1;
    step(1);
    evt_in = 1'b0;
    chk(count, exp_cnt, "R8 not yet visible");
    step(1);
    exp_cnt = exp_cnt + 1;
    chk(count, exp_cnt, "R8 visible after two edges");
    evt_in = 1'b1;
    step(5);
    evt_in = 1'b0;
    step(2);
    exp_cnt = exp_cnt + 5;
    chk(count, exp_cnt, "R8 burst of five");

    // R11 load over staged event
    evt_in = 1'b1;
    step(1);
    evt_in = 1'b0; sw_ld = 1'b1; sw_ld_val = 40'h12_3456_789A;
    step(1);
    sw_ld = 1'b0;
    step(2);
    chk(count, 40'h12_3456_789A, "R11 load beats staged event");

    // R9 overflow
    sw_ld = 1'b1; sw_ld_val = '1;
    step(1);
    sw_ld = 1'b0;
    chk({39'd0, ovf}, '0, "R9 ovf clear before wrap");
    pulse();
    chk(count, '0, "R9 wrap to zero");
    chk({39'd0, ovf}, 40'd1, "R9 ovf set on wrap");
    pulse();
    chk({39'd0, ovf}, 40'd1, "R9 ovf sticky");
    sw_ld = 1'b1; sw_ld_val = 40'd5;
    step(1);
    sw_ld = 1'b0;
    chk({39'd0, ovf}, 40'd1, "R11 load keeps ovf");
    chk(count, 40'd5, "R11 load value");

    // R10 clear beats load
    sw_clr = 1'b1; sw_ld = 1'b1; sw_ld_val = 40'd77;
    step(1);
    sw_clr = 1'b0; sw_ld = 1'b0;
    chk(count, '0, "R10 clear beats load");
    chk({39'd0, ovf}, '0, "R10 clear drops ovf");
    evt_in = 1'b1;
    step(1);
    evt_in = 1'b0; sw_clr = 1'b1;
    step(1);
    sw_clr = 1'b0;
    step(2);
    chk(count, '0, "R10 clear beats staged event");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule